// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt request lines and a small CPU core. It latches each request into a pending flag and picks the best pending source by a 2-bit programmable level per source. It then raises a one-cycle acknowledge with the source's vector index. A global enable flag gates every acknowledge and is cleared by each one, so a handler must issue an enable strobe before any nesting can happen.

The block keeps a small stack of the levels currently in service. A pending request interrupts a running handler only when its level is strictly better than the level at the top of the stack. A request that is not better waits. A return strobe pops the stack and sets the enable flag again. After any return, no acknowledge is given until the core has reported one retired instruction of the resumed code.

Top module: `nested_irq_ctrl`

## Requirements
- R1: Source i takes its level from `prio_i[2i+1:2i]`. Code 0 is the most urgent level and code 3 the least urgent. Among pending sources, the one with the numerically smallest level is granted.
- R2: When several pending sources share the best level, the one with the lowest index is granted.
- R3: The global enable `ie_o` is 0 after reset. While it is 0, no acknowledge is issued.
- R4: An acknowledge is a one-cycle pulse on `ack_o`, with `vec_o` holding the granted index. In the cycle the pulse is visible, `ie_o` is already 0 and the granted source's pending flag is cleared.
- R5: `ei_i` sets `ie_o` and `di_i` clears it. When both arrive in the same cycle, the set wins.
- R6: With a non-empty in-service stack, a request is granted only if its level is strictly smaller than the top level. An equal level does not nest.
- R7: A request that cannot be granted stays pending. It is granted once it becomes eligible, without being raised again.
- R8: After `reti_i`, no acknowledge is issued until `instr_done_i` has been seen in a later cycle. The earliest acknowledge comes two cycles after that strobe.
- R9: Every acknowledge pushes its level on a stack that holds up to 4 levels, and `reti_i` pops it. `reti_i` always sets `ie_o` to 1, and with an empty stack that is its only effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_SRC | Request lines, latched into pending flags |
| prio_i | input | 2*N_SRC | Per-source level, 2 bits per source |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| reti_i | input | 1 | Return-from-interrupt strobe |
| instr_done_i | input | 1 | Instruction-retired strobe |
| ack_o | output | 1 | Acknowledge pulse |
| vec_o | output | $clog2(N_SRC) | Index of the granted source |
| ie_o | output | 1 | Global enable flag |

## Verification
The arbitration is swept over every assignment of levels to the four sources and every non-empty set of raised requests. Each set is drained one grant per handler, so the full order of grants is compared against a sort by level and then by index. This order tells level priority apart from index priority. A ladder of four strictly better levels checks that nesting works at full stack depth. It then unwinds and checks that worse and equal requests stay held. Separate runs with enable clear and with returns that are not yet followed by a retired instruction show that each gate blocks a grant while it is active and releases the held request afterwards.

// File: rtl/npic_pkg.sv
package npic_pkg;
  localparam int unsigned LVL_W = 2;
  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/npic_pend.sv
module npic_pend #(
  parameter int unsigned N_SRC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] irq_i,
  input  logic [N_SRC-1:0] clr_i,
  output logic [N_SRC-1:0] pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_o <= '0;
    else         pend_o <= (pend_o | irq_i) & ~clr_i;
  end
endmodule

// File: rtl/npic_arb.sv
module npic_arb
  import npic_pkg::*;
#(
  parameter int unsigned N_SRC = 4,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       pend_i,
  input  logic [N_SRC*LVL_W-1:0] prio_i,
  output logic                   any_o,
  output logic [IDX_W-1:0]       idx_o,
  output lvl_t                   lvl_o
);
  lvl_t lvl_a [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_unpack
    assign lvl_a[g] = prio_i[g*LVL_W +: LVL_W];
  end

  // strict compare keeps the lowest index on ties
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    lvl_o = '1;
    for (int i = 0; i < N_SRC; i++) begin
      if (pend_i[i] && (!any_o || lvl_a[i] < lvl_o)) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
        lvl_o = lvl_a[i];
      end
    end
  end
endmodule

// File: rtl/npic_lvl_stack.sv
module npic_lvl_stack
  import npic_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             pop_i,
  input  lvl_t             lvl_i,
  output lvl_t             top_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] cnt_o
);
  lvl_t             mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q;
  logic [PTR_W-1:0] top_ptr, wr_ptr;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign cnt_o   = cnt_q;
  assign top_ptr = PTR_W'(cnt_q - 1'b1);
  assign wr_ptr  = PTR_W'(cnt_q);
  assign top_o   = empty_o ? '1 : mem_q[top_ptr];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && !full_o) begin
      mem_q[wr_ptr] <= lvl_i;
      cnt_q         <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import npic_pkg::*;
#(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       irq_i,
  input  logic [N_SRC*LVL_W-1:0] prio_i,
  input  logic                   ei_i,
  input  logic                   di_i,
  input  logic                   reti_i,
  input  logic                   instr_done_i,
  output logic                   ack_o,
  output logic [IDX_W-1:0]       vec_o,
  output logic                   ie_o
);
  logic [N_SRC-1:0] pend, clr;
  logic             any;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl, stk_top;
  logic             stk_empty, stk_full;
  logic [CNT_W-1:0] stk_depth;
  logic             ie_q, hold_q, ack_q, take, elig;
  logic [IDX_W-1:0] vec_q;

  npic_pend #(.N_SRC(N_SRC)) pend_i (
    .clk_i, .rst_ni, .irq_i, .clr_i(clr), .pend_o(pend)
  );

  npic_arb #(.N_SRC(N_SRC)) arb_i (
    .pend_i(pend), .prio_i, .any_o(any), .idx_o(win_idx), .lvl_o(win_lvl)
  );

  npic_lvl_stack #(.DEPTH(DEPTH)) stk_i (
    .clk_i, .rst_ni, .push_i(take), .pop_i(reti_i), .lvl_i(win_lvl),
    .top_o(stk_top), .empty_o(stk_empty), .full_o(stk_full), .cnt_o(stk_depth)
  );

  assign elig = stk_empty || (win_lvl < stk_top);
  assign take = ie_q && any && elig && !hold_q && !stk_full && !reti_i && !di_i;
  assign clr  = {{(N_SRC-1){1'b0}}, take} << win_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      hold_q <= 1'b0;
      ack_q  <= 1'b0;
      vec_q  <= '0;
    end else begin
      ack_q <= take;
      if (take) vec_q <= win_idx;
      if (take)                ie_q <= 1'b0;
      else if (reti_i || ei_i) ie_q <= 1'b1;
      else if (di_i)           ie_q <= 1'b0;
      // one retired instruction of resumed code before next grant
      if (reti_i)            hold_q <= 1'b1;
      else if (instr_done_i) hold_q <= 1'b0;
    end
  end

  assign ack_o = ack_q;
  assign vec_o = vec_q;
  assign ie_o  = ie_q;
endmodule

// File: rtl/npic_chk.sv
module npic_chk
  import npic_pkg::*;
#(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_SRC*LVL_W-1:0] prio_i,
  input logic                   reti_i,
  input logic                   ack_o,
  input logic [IDX_W-1:0]       vec_o,
  input logic                   ie_o,
  input logic                   stk_empty,
  input lvl_t                   stk_top,
  input logic [CNT_W-1:0]       stk_depth
);
  function automatic lvl_t lvl_of(input logic [N_SRC*LVL_W-1:0] p, input logic [IDX_W-1:0] i);
    return p[i*LVL_W +: LVL_W];
  endfunction

  a_r3_ack_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(ie_o));

  a_r4_ack_clears_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !ie_o);

  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  a_r6_strict_nest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && !$past(stk_empty)) |-> (lvl_of($past(prio_i), vec_o) < $past(stk_top)));

  a_r8_no_ack_after_reti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !$past(reti_i));

  a_r9_reti_sets_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i |=> ie_o);

  a_r9_push_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (stk_depth == $past(stk_depth) + 1'b1));

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stk_depth <= CNT_W'(DEPTH));
endmodule

bind nested_irq_ctrl npic_chk #(.N_SRC(N_SRC), .DEPTH(DEPTH)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .prio_i(prio_i), .reti_i(reti_i),
  .ack_o(ack_o), .vec_o(vec_o), .ie_o(ie_o),
  .stk_empty(stk_empty), .stk_top(stk_top), .stk_depth(stk_depth)
);

// File: tb/nested_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module nested_irq_ctrl_tb_top;
  localparam int N = 4;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] irq_i = '0;
  logic [2*N-1:0] prio_i = '0;
  logic ei_i = 0, di_i = 0, reti_i = 0, instr_done_i = 0;
  logic         ack_o, ie_o;
  logic [1:0]   vec_o;
  int checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  nested_irq_ctrl #(.N_SRC(N), .DEPTH(4)) dut_i (
    .clk_i, .rst_ni, .irq_i, .prio_i, .ei_i, .di_i, .reti_i, .instr_done_i,
    .ack_o, .vec_o, .ie_o
  );

  task automatic tick(); @(negedge clk_i); endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_ack(input int lim, output bit got, output int v);
    got = 0; v = -1;
    for (int k = 0; k < lim && !got; k++) begin
      tick();
      if (ack_o) begin got = 1; v = int'(vec_o); end
    end
  endtask

  task automatic no_ack(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      tick();
      chk(ack_o == 1'b0, req, int'(ack_o), 0);
    end
  endtask

  task automatic pulse(input logic [N-1:0] m, input bit en);
    irq_i = m; ei_i = en; tick(); irq_i = '0; ei_i = 0;
  endtask

  task automatic do_reti(); reti_i = 1; tick(); reti_i = 0; endtask
  task automatic do_done(); instr_done_i = 1; tick(); instr_done_i = 0; endtask
  task automatic do_di(); di_i = 1; tick(); di_i = 0; endtask

  task automatic expect_ack(input int exp, input string req);
    bit got; int v;
    wait_ack(4, got, v);
    chk(got && v == exp, req, v, exp);
    chk(ie_o == 1'b0, "R4 ie cleared", int'(ie_o), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit got; int v;
    repeat (3) tick();
    chk(ie_o == 0, "R3 reset ie", int'(ie_o), 0);
    chk(ack_o == 0, "R3 reset ack", int'(ack_o), 0);
    rst_ni = 1;
    tick();
    chk(ie_o == 0, "R3 ie after reset", int'(ie_o), 0);

    // R3/R7: request with ie clear is held, then granted on EI
    pulse(4'b0001, 0);
    no_ack(3, "R3 blocked by ie");
    pulse('0, 1);
    wait_ack(4, got, v);
    chk(got && v == 0, "R7 held request", v, 0);
    tick();
    chk(ack_o == 0, "R4 one-cycle pulse", int'(ack_o), 0);
    do_reti(); do_done();

    // R5 set/clear, set wins over clear
    do_di();
    chk(ie_o == 0, "R5 di clears", int'(ie_o), 0);
    ei_i = 1; tick(); ei_i = 0;
    chk(ie_o == 1, "R5 ei sets", int'(ie_o), 1);
    do_di();
    chk(ie_o == 0, "R5 di clears", int'(ie_o), 0);
    ei_i = 1; di_i = 1; tick(); ei_i = 0; di_i = 0;
    chk(ie_o == 1, "R5 ei wins", int'(ie_o), 1);

    // R1/R2 sweep: all level maps x all request sets, drained in order
    for (int pv = 0; pv < 256; pv++) begin
      for (int m = 1; m < 16; m++) begin
        logic [3:0] rem;
        do_di();
        prio_i = 8'(pv);
        rem = 4'(m);
        pulse(4'(m), 1);
        while (rem != 0) begin
          int best, bl;
          best = -1; bl = 4;
          for (int i = 0; i < N; i++)
            if (rem[i] && ((pv >> (2*i)) & 3) < bl) begin best = i; bl = (pv >> (2*i)) & 3; end
          expect_ack(best, "R1 R2 grant order");
          rem[best] = 1'b0;
          do_reti();
          if (rem != 0 && m == 15) no_ack(2, "R8 wait retire");
          do_done();
        end
      end
    end

    // R6/R9 nesting ladder 3 -> 2 -> 1 -> 0
    do_di();
    prio_i = {2'd0, 2'd1, 2'd2, 2'd3};
    pulse(4'b0001, 1); expect_ack(0, "R9 depth1");
    pulse(4'b0010, 1); expect_ack(1, "R6 nest depth2");
    pulse(4'b0100, 1); expect_ack(2, "R6 nest depth3");
    pulse(4'b1000, 1); expect_ack(3, "R9 nest depth4");
    pulse(4'b0001, 1); no_ack(3, "R6 lower held");
    do_reti(); do_done(); no_ack(2, "R6 lower vs 1");
    do_reti(); do_done(); no_ack(2, "R6 lower vs 2");
    do_reti(); do_done(); no_ack(2, "R6 equal vs 3");
    do_reti(); no_ack(3, "R8 gate");
    do_done(); expect_ack(0, "R7 released");
    do_reti(); do_done();

    // R6 equal level does not nest; R7/R8 release order
    do_di();
    prio_i = {2'd3, 2'd3, 2'd2, 2'd2};
    pulse(4'b0001, 1); expect_ack(0, "R6 base");
    pulse(4'b0010, 1); no_ack(3, "R6 equal no nest");
    pulse(4'b0100, 0); no_ack(2, "R7 lower held");
    do_reti(); no_ack(3, "R8 no retire yet");
    do_done(); expect_ack(1, "R7 equal released");
    do_reti(); do_done(); expect_ack(2, "R7 lower released");
    do_reti(); do_done();

    // R9 reti on empty stack only sets ie
    do_di();
    chk(ie_o == 0, "R9 pre", int'(ie_o), 0);
    do_reti();
    chk(ie_o == 1, "R9 empty reti sets ie", int'(ie_o), 1);
    do_done(); no_ack(2, "R9 empty reti no grant");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule